// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of storage stages with two ways to fill it. It can be filled all at once from a parallel data word, or it can be advanced one position at a time toward its last stage, with a serial input bit entering the first stage on each advance. The value of the last stage leaves the block on two pins, one true and one inverted. A typical use is reading a bank of switches or status lines into one serial stream.

The controls come from outside, with no timing relation to the system clock. These are two shift-clock inputs, an active-low load request and the serial data bit. Each one passes through a synchronizer before the block uses it. Either shift-clock input can gate the other one, because the block advances on a rising edge of their logical OR. While the load request is active, the stages follow the parallel word on every system clock cycle, and the shift clocks and the serial bit have no effect.

A four-state controller records two facts from the previous cycle: whether the load request was active, and whether the combined shift clock was high. The states are ARMED (no load, clock low), HELD (no load, clock high), LOAD_LOW (loading, clock low) and LOAD_HIGH (loading, clock high). Every cycle the controller moves to the state named by the current synchronized inputs. The ARMED to HELD move is the advance edge. The LOAD_LOW to HELD move is also an advance edge, because the load ends in the same cycle. The HELD to ARMED move and every move into a LOAD state perform no advance. A rising edge seen in the ARMED to LOAD_HIGH move is taken over by the load.

Top module: `pload_shreg`

## Requirements
- R1: Reset is synchronous and active low. It clears every stage to 0, so tail_q is 0 and tail_qn is 1. It also clears the edge history so the combined shift clock counts as low.
- R2: While load_n is low after synchronization, every stage takes its bit of par_din on each system clock cycle, whatever ext_clk_a, ext_clk_b and ser_din are doing. par_din bit 0 feeds the first stage and bit STAGES-1 feeds the last stage, which drives tail_q.
- R3: A change on load_n, ext_clk_a, ext_clk_b or ser_din takes effect in the stages at the third rising system clock edge after the change, because it passes through two synchronizer flops. It cannot take effect earlier.
- R4: The advance clock is the OR of ext_clk_a and ext_clk_b. A 0-to-1 change of this OR gives exactly one advance, whichever input caused it.
- R5: On an advance, stage i takes the old value of stage i-1, and the first stage takes the synchronized ser_din from the same cycle.
- R6: With load_n high, the stages keep their contents when there is no rising edge of the OR. This holds while either input stays high and the other toggles.
- R7: If a load and a detected rising edge fall in the same cycle, the load wins. Releasing the load while the OR stays high causes no advance.
- R8: tail_qn is always the complement of tail_q.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_a | input | 1 | First shift-clock input; asynchronous |
| ext_clk_b | input | 1 | Second shift-clock input, interchangeable with the first; asynchronous |
| load_n | input | 1 | Active-low parallel load request; asynchronous |
| ser_din | input | 1 | Serial bit that enters the first stage on an advance |
| par_din | input | STAGES | Parallel word; bit 0 feeds the first stage |
| tail_q | output | 1 | Value of the last stage |
| tail_qn | output | 1 | Complement of the last stage |

## Verification
The two functions that can land in one cycle are a parallel load and a detected rising edge of the combined shift clock. The bench provokes this by raising a shift-clock input on the same drive step that pulls load_n low. Both signals go through synchronizers of equal depth, so they reach the controller together. The bench then releases the load while that clock stays high. It loads a word whose last two bits differ, so a wrong advance would show as a different tail_q value. Random stimulus also produces many such overlaps, and each one is judged against a cycle-accurate model inside the bench.

// File: rtl/pload_pkg.sv
package pload_pkg;

    // Controller state: {load active, combined shift clock high} of the previous cycle
    typedef enum logic [1:0] {
        ST_ARMED     = 2'b00,
        ST_HELD      = 2'b01,
        ST_LOAD_LOW  = 2'b10,
        ST_LOAD_HIGH = 2'b11
    } ctl_state_e;

    // Operation applied to the stage array in a cycle
    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_SHIFT = 2'b10
    } stage_op_e;

endpackage

// File: rtl/pload_sync.sv
module pload_sync #(
    parameter int               WIDTH   = 4,
    parameter int               DEPTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                chain[i] <= RST_VAL;
            end
        end else begin
            chain[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[DEPTH-1];

endmodule

// File: rtl/pload_ctrl.sv
module pload_ctrl
    import pload_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_req,
    input  logic      eff_clk,
    output logic      edge_seen,
    output stage_op_e op
);

    ctl_state_e state_q;
    ctl_state_e state_d;

    // Next state follows the present synchronized inputs
    always_comb begin
        if (load_req) begin
            state_d = eff_clk ? ST_LOAD_HIGH : ST_LOAD_LOW;
        end else begin
            state_d = eff_clk ? ST_HELD : ST_ARMED;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: edge when clock was low last cycle and is high now; load has priority
    always_comb begin
        edge_seen = 1'b0;
        op        = OP_HOLD;
        unique case (state_q)
            ST_ARMED:     edge_seen = eff_clk;
            ST_LOAD_LOW:  edge_seen = eff_clk;
            ST_HELD:      edge_seen = 1'b0;
            ST_LOAD_HIGH: edge_seen = 1'b0;
        endcase
        if (load_req) begin
            op = OP_LOAD;
        end else if (edge_seen) begin
            op = OP_SHIFT;
        end
    end

endmodule

// File: rtl/pload_stages.sv
module pload_stages
    import pload_pkg::*;
#(
    parameter int STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stage_op_e         op,
    input  logic [STAGES-1:0] par_din,
    input  logic              ser_bit,
    output logic [STAGES-1:0] stage_q
);

    logic [STAGES-1:0] stage_d;

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            logic from_prev;
            if (gi == 0) begin : g_head
                assign from_prev = ser_bit;
            end else begin : g_body
                assign from_prev = stage_q[gi-1];
            end
            always_comb begin
                unique case (op)
                    OP_LOAD:  stage_d[gi] = par_din[gi];
                    OP_SHIFT: stage_d[gi] = from_prev;
                    default:  stage_d[gi] = stage_q[gi];
                endcase
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

endmodule

// File: rtl/pload_shreg.sv
module pload_shreg
    import pload_pkg::*;
#(
    parameter int STAGES     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_clk_a,
    input  logic              ext_clk_b,
    input  logic              load_n,
    input  logic              ser_din,
    input  logic [STAGES-1:0] par_din,
    output logic              tail_q,
    output logic              tail_qn
);

    localparam int               NSYNC    = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0100; // load request idle (high)

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] sync_out;
    logic             a_s;
    logic             b_s;
    logic             load_n_s;
    logic             ser_s;
    logic             edge_seen;
    stage_op_e        op;
    logic [STAGES-1:0] stage_q;

    assign raw_in = {ser_din, load_n, ext_clk_b, ext_clk_a};

    pload_sync #(
        .WIDTH  (NSYNC),
        .DEPTH  (SYNC_DEPTH),
        .RST_VAL(SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (sync_out)
    );

    assign a_s      = sync_out[0];
    assign b_s      = sync_out[1];
    assign load_n_s = sync_out[2];
    assign ser_s    = sync_out[3];

    pload_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_req (~load_n_s),
        .eff_clk  (a_s | b_s),
        .edge_seen(edge_seen),
        .op       (op)
    );

    pload_stages #(
        .STAGES(STAGES)
    ) u_stages (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (op),
        .par_din(par_din),
        .ser_bit(ser_s),
        .stage_q(stage_q)
    );

    assign tail_q  = stage_q[STAGES-1];
    assign tail_qn = ~stage_q[STAGES-1];

endmodule

// File: rtl/pload_shreg_chk.sv
module pload_shreg_chk
    import pload_pkg::*;
#(
    parameter int STAGES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              a_s,
    input logic              b_s,
    input logic              load_n_s,
    input logic              ser_s,
    input logic              edge_seen,
    input stage_op_e         op,
    input logic [STAGES-1:0] stage_q,
    input logic [STAGES-1:0] par_din,
    input logic              tail_q,
    input logic              tail_qn
);

    p_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tail_qn != tail_q);

    p_load_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_n_s |=> stage_q == $past(par_din));

    p_rise_detect_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_s || b_s) && !$past(a_s || b_s)) |-> edge_seen);

    p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> !edge_seen);

    p_shift_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && edge_seen) |=>
            stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_s)});

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n_s && !edge_seen) |=> $stable(stage_q));

    p_load_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n_s && edge_seen) |-> op == OP_LOAD);

endmodule

bind pload_shreg pload_shreg_chk #(
    .STAGES(STAGES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_s      (a_s),
    .b_s      (b_s),
    .load_n_s (load_n_s),
    .ser_s    (ser_s),
    .edge_seen(edge_seen),
    .op       (op),
    .stage_q  (stage_q),
    .par_din  (par_din),
    .tail_q   (tail_q),
    .tail_qn  (tail_qn)
);

// File: tb/pload_shreg_bench.sv
module pload_shreg_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int STAGES      = 8;
    localparam int WDOG_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clk_a = 1'b0;
    logic clk_b = 1'b0;
    logic load_n = 1'b1;
    logic ser = 1'b0;
    logic [STAGES-1:0] par = '0;
    logic tail_q;
    logic tail_qn;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    pload_shreg #(.STAGES(STAGES)) u_pload_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_clk_a(clk_a),
        .ext_clk_b(clk_b),
        .load_n   (load_n),
        .ser_din  (ser),
        .par_din  (par),
        .tail_q   (tail_q),
        .tail_qn  (tail_qn)
    );

    // Expected-value model built from R1-style reset, two-flop latency (R3), and the load/shift/hold rules
    logic [3:0]        m1;
    logic [3:0]        m2;
    logic              m_prev;
    logic [STAGES-1:0] m_st;

    function automatic logic [STAGES-1:0] next_stages(
        input logic [STAGES-1:0] cur, input logic [3:0] smp,
        input logic prev, input logic [STAGES-1:0] p);
        logic eff;
        eff = smp[0] | smp[1];
        if (!smp[2]) return p;
        if (eff && !prev) return {cur[STAGES-2:0], smp[3]};
        return cur;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m1     <= 4'b0100;
            m2     <= 4'b0100;
            m_prev <= 1'b0;
            m_st   <= '0;
        end else begin
            m1     <= {ser, load_n, clk_b, clk_a};
            m2     <= m1;
            m_st   <= next_stages(m_st, m2, m_prev, par);
            m_prev <= m2[0] | m2[1];
        end
    end

    task automatic check_bit(input logic got, input logic exp, input string req, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic cyc(input logic a, input logic b, input logic ld, input logic s);
        @(negedge clk);
        check_bit(tail_q, m_st[STAGES-1], cur_req, "tail_q vs model");
        check_bit(tail_qn, ~m_st[STAGES-1], "R8", "tail_qn complement");
        clk_a  = a;
        clk_b  = b;
        load_n = ld;
        ser    = s;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(clk_a, clk_b, load_n, ser);
    endtask

    initial begin
        #(CLK_PERIOD * WDOG_CYCLES);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] sbits;
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_bit(tail_q, 1'b0, "R1", "tail_q after reset");
        check_bit(tail_qn, 1'b1, "R1", "tail_qn after reset");

        // R3: load of all ones appears at the third edge, not earlier
        cur_req = "R3";
        par = 8'hFF;
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        check_bit(tail_q, 1'b0, "R3", "before third edge");
        cyc(0, 0, 0, 0);
        check_bit(tail_q, 1'b1, "R3", "at third edge");
        cyc(0, 0, 1, 0);
        idle(4);

        // R1: mid-run reset clears the loaded ones
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_bit(tail_q, 1'b0, "R1", "tail_q after mid-run reset");
        check_bit(tail_qn, 1'b1, "R1", "tail_qn after mid-run reset");

        // R2: load while clocks and serial toggle
        cur_req = "R2";
        par = 8'h5A;
        for (int i = 0; i < 8; i++) cyc(i[0], i[1], 0, ~i[0]);
        cyc(0, 0, 0, 0);
        idle(3);
        check_bit(tail_q, 1'b0, "R2", "last stage holds bit 7 of 8'h5A");
        cyc(0, 0, 1, 0);
        idle(3);

        // R5: shift out via ext_clk_a with a serial pattern
        cur_req = "R5";
        sbits = 8'b1100_1011;
        for (int i = 0; i < 8; i++) begin
            cyc(1, 0, 1, sbits[i]);
            idle(2);
            cyc(0, 0, 1, sbits[i]);
            idle(2);
        end
        idle(3);
        check_bit(tail_q, sbits[0], "R5", "first serial bit reached last stage");

        // R4: shift using ext_clk_b alone
        cur_req = "R4";
        for (int i = 0; i < 4; i++) begin
            cyc(0, 1, 1, 1'b0);
            idle(2);
            cyc(0, 0, 1, 1'b0);
            idle(2);
        end

        // R6: hold while one input is high and the other toggles
        cur_req = "R6";
        cyc(1, 0, 1, 1);
        idle(3);
        for (int i = 0; i < 6; i++) begin
            cyc(1, i[0], 1, i[1]);
            idle(2);
        end
        cyc(0, 1, 1, 1);
        idle(3);
        for (int i = 0; i < 6; i++) begin
            cyc(i[0], 1, 1, i[1]);
            idle(2);
        end
        cyc(0, 0, 1, 0);
        idle(3);

        // R7: rising edge and load together; release with clock still high
        cur_req = "R7";
        par = 8'h80;
        cyc(1, 0, 0, 0);
        idle(5);
        cyc(1, 0, 1, 0);
        idle(5);
        check_bit(tail_q, 1'b1, "R7", "no shift after load release");
        cyc(0, 0, 1, 0);
        idle(3);

        // Random mix of loads, edges, holds
        cur_req = "R2/R4/R5/R6/R7";
        for (int i = 0; i < 3000; i++) begin
            logic a, b, ld;
            a  = clk_a;
            b  = clk_b;
            ld = load_n;
            if ($urandom_range(3) == 0) a = ~a;
            if ($urandom_range(4) == 0) b = ~b;
            if ($urandom_range(9) == 0) ld = ~ld;
            if ($urandom_range(7) == 0) par = 8'($urandom);
            cyc(a, b, ld, 1'($urandom));
        end
        idle(4);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule